// File: doc/BRIEF.md
# Registered Integer ALU with Two-Level Opcode Decode

This block is the integer execution stage of a 32-bit RISC core with 32 architectural registers and 16-bit immediates. Each cycle it receives one instruction word together with the two source register values already read from the register file. It decodes the instruction and computes the result of one integer operation: addition and subtraction, bitwise logic, compares, or a shift or rotate. It returns the result, the destination register index, a write-enable and a flag for operations it does not handle. All outputs are registered, so results appear one clock after the inputs.

The 6-bit primary opcode picks the operation for immediate-format words. One primary code marks register-format words, and for those a 6-bit secondary code picks the operation. Immediate forms extend their 16-bit field in one of three ways: sign extension, zero extension, or placement in the upper halfword. Compares write 0 or 1 into the destination register and set no flags.

Top module: `rx_int_alu`

## Requirements
- R1: While `rst_n` is low, `result_o`, `dest_o`, `wr_en_o` and `illegal_o` are all zero.
- R2: The outputs show the decode of the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R3: The instruction fields are: source A at bits 31:27, field B at 26:22, primary opcode at 5:0, IMM16 at 21:6, field C at 21:17, secondary opcode at 16:11 and IMM5 at 10:6. The destination is B for immediate format and C when the primary opcode is 0x3A.
- R4: Register add (secondary 0x31) returns A+B modulo 2^32 and register sub (0x39) returns A-B. The addi instruction (primary 0x04) adds the sign-extended IMM16.
- R5: Register logic returns A&B for secondary 0x0E, A|B for 0x16, A^B for 0x1E and ~(A|B) for 0x06.
- R6: The primary codes 0x0C, 0x14 and 0x1C perform AND, OR and XOR with the zero-extended IMM16. The primary codes 0x2C, 0x34 and 0x3C perform the same three operations with {IMM16,16'h0000}.
- R7: Compares return 1 when their condition holds and 0 otherwise. The codes are eq 0x20, ne 0x18, signed ge 0x08, unsigned ge 0x28, signed lt 0x10 and unsigned lt 0x30. They are secondary codes for the register forms and the same values as primary codes for the immediate forms. Immediate eq, ne, ge and lt sign-extend IMM16. Immediate geu and ltu zero-extend it.
- R8: Register shifts use only bits 4:0 of operand B: sll (0x13) fills with zeros, srl (0x1B) fills with zeros, and sra (0x3B) fills with the sign bit.
- R9: Register rotates rol (0x03) and ror (0x0B) move bits out of one end and back in at the other, by B[4:0] positions.
- R10: The immediate shift forms slli 0x12, srli 0x1A, srai 0x3A and roli 0x02 take their amount from IMM5 and ignore operand B.
- R11: A legal operation whose destination is register 0 still outputs its result and destination index, but `wr_en_o` is low.
- R12: Any primary code not listed in R4 to R7 and R3 is illegal, including 0x00. Any secondary code not listed in R4, R5 and R7 to R10 is also illegal. An illegal operation sets `illegal_o`=1 and drives `wr_en_o`, `result_o` and `dest_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 32 | Value of source register A |
| src_b_i | input | 32 | Value of source register B |
| result_o | output | 32 | Registered operation result |
| dest_o | output | 5 | Registered destination register index |
| wr_en_o | output | 1 | Registered register-file write-enable |
| illegal_o | output | 1 | Registered flag for unsupported operations |

## Verification
Two suppression conditions can apply in the same cycle: an unsupported opcode and a destination of register 0. The bench provokes this with unsupported primary and secondary codes whose destination field is 0. It then checks that the illegal flag wins and clears the result and destination, not only the write-enable. A second coincidence is a register shift or rotate whose operand B has upper bits set. In that case the amount must come from B[4:0] alone, while a sign fill or a wrap applies in the same result. A behavioural model in the bench predicts every output one clock later, for directed corner words and for thousands of pseudo-random words drawn from both legal and unassigned codes.

// File: rtl/rx_alu_pkg.sv
package rx_alu_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RIDX_W = $clog2(NREGS);
    localparam int SHW    = $clog2(XLEN);
    localparam int OPC_W  = 6;
    localparam int IMM_W  = 16;

    // primary opcodes
    localparam logic [OPC_W-1:0] P_REG    = 6'h3A;
    localparam logic [OPC_W-1:0] P_ADDI   = 6'h04;
    localparam logic [OPC_W-1:0] P_ANDI   = 6'h0C;
    localparam logic [OPC_W-1:0] P_ORI    = 6'h14;
    localparam logic [OPC_W-1:0] P_XORI   = 6'h1C;
    localparam logic [OPC_W-1:0] P_ANDHI  = 6'h2C;
    localparam logic [OPC_W-1:0] P_ORHI   = 6'h34;
    localparam logic [OPC_W-1:0] P_XORHI  = 6'h3C;

    // compare codes, shared by both opcode spaces
    localparam logic [OPC_W-1:0] C_EQ  = 6'h20;
    localparam logic [OPC_W-1:0] C_NE  = 6'h18;
    localparam logic [OPC_W-1:0] C_GE  = 6'h08;
    localparam logic [OPC_W-1:0] C_GEU = 6'h28;
    localparam logic [OPC_W-1:0] C_LT  = 6'h10;
    localparam logic [OPC_W-1:0] C_LTU = 6'h30;

    // secondary codes
    localparam logic [OPC_W-1:0] S_ADD  = 6'h31;
    localparam logic [OPC_W-1:0] S_SUB  = 6'h39;
    localparam logic [OPC_W-1:0] S_AND  = 6'h0E;
    localparam logic [OPC_W-1:0] S_OR   = 6'h16;
    localparam logic [OPC_W-1:0] S_XOR  = 6'h1E;
    localparam logic [OPC_W-1:0] S_NOR  = 6'h06;
    localparam logic [OPC_W-1:0] S_SLL  = 6'h13;
    localparam logic [OPC_W-1:0] S_SRL  = 6'h1B;
    localparam logic [OPC_W-1:0] S_SRA  = 6'h3B;
    localparam logic [OPC_W-1:0] S_ROL  = 6'h03;
    localparam logic [OPC_W-1:0] S_ROR  = 6'h0B;
    localparam logic [OPC_W-1:0] S_SLLI = 6'h12;
    localparam logic [OPC_W-1:0] S_SRLI = 6'h1A;
    localparam logic [OPC_W-1:0] S_SRAI = 6'h3A;
    localparam logic [OPC_W-1:0] S_ROLI = 6'h02;

    typedef enum logic [4:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_EQ, K_NE, K_GE, K_GEU, K_LT, K_LTU,
        K_SLL, K_SRL, K_SRA, K_ROL, K_ROR, K_BAD
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [XLEN-1:0]   opnd2;
        logic [RIDX_W-1:0] dest;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0]   result;
        logic [RIDX_W-1:0] dest;
        logic              wr_en;
        logic              illegal;
    } out_t;

endpackage

// File: rtl/rx_alu_decode.sv
module rx_alu_decode
    import rx_alu_pkg::*;
(
    input  logic [26:0]     word_i,
    input  logic [XLEN-1:0] src_b_i,
    output dec_t            dec_o
);
    logic [OPC_W-1:0]  prim;
    logic [OPC_W-1:0]  sec;
    logic [IMM_W-1:0]  imm16;
    logic [4:0]        imm5;
    logic [XLEN-1:0]   imm_sx, imm_zx, imm_hi, imm_sh;

    always_comb begin
        prim   = word_i[5:0];
        sec    = word_i[16:11];
        imm16  = word_i[21:6];
        imm5   = word_i[10:6];
        imm_sx = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
        imm_zx = {{(XLEN-IMM_W){1'b0}}, imm16};
        imm_hi = {imm16, {(XLEN-IMM_W){1'b0}}};
        imm_sh = {{(XLEN-5){1'b0}}, imm5};

        dec_o.kind  = K_BAD;
        dec_o.opnd2 = imm_zx;
        dec_o.dest  = word_i[26:22];

        unique case (prim)
            P_REG: begin
                dec_o.dest  = word_i[21:17];
                dec_o.opnd2 = src_b_i;
                case (sec)
                    S_ADD:  dec_o.kind = K_ADD;
                    S_SUB:  dec_o.kind = K_SUB;
                    S_AND:  dec_o.kind = K_AND;
                    S_OR:   dec_o.kind = K_OR;
                    S_XOR:  dec_o.kind = K_XOR;
                    S_NOR:  dec_o.kind = K_NOR;
                    C_EQ:   dec_o.kind = K_EQ;
                    C_NE:   dec_o.kind = K_NE;
                    C_GE:   dec_o.kind = K_GE;
                    C_GEU:  dec_o.kind = K_GEU;
                    C_LT:   dec_o.kind = K_LT;
                    C_LTU:  dec_o.kind = K_LTU;
                    S_SLL:  dec_o.kind = K_SLL;
                    S_SRL:  dec_o.kind = K_SRL;
                    S_SRA:  dec_o.kind = K_SRA;
                    S_ROL:  dec_o.kind = K_ROL;
                    S_ROR:  dec_o.kind = K_ROR;
                    S_SLLI: begin dec_o.kind = K_SLL; dec_o.opnd2 = imm_sh; end
                    S_SRLI: begin dec_o.kind = K_SRL; dec_o.opnd2 = imm_sh; end
                    S_SRAI: begin dec_o.kind = K_SRA; dec_o.opnd2 = imm_sh; end
                    S_ROLI: begin dec_o.kind = K_ROL; dec_o.opnd2 = imm_sh; end
                    default: dec_o.kind = K_BAD;
                endcase
            end
            P_ADDI:  begin dec_o.kind = K_ADD; dec_o.opnd2 = imm_sx; end
            P_ANDI:  dec_o.kind = K_AND;
            P_ORI:   dec_o.kind = K_OR;
            P_XORI:  dec_o.kind = K_XOR;
            P_ANDHI: begin dec_o.kind = K_AND; dec_o.opnd2 = imm_hi; end
            P_ORHI:  begin dec_o.kind = K_OR;  dec_o.opnd2 = imm_hi; end
            P_XORHI: begin dec_o.kind = K_XOR; dec_o.opnd2 = imm_hi; end
            C_EQ:    begin dec_o.kind = K_EQ;  dec_o.opnd2 = imm_sx; end
            C_NE:    begin dec_o.kind = K_NE;  dec_o.opnd2 = imm_sx; end
            C_GE:    begin dec_o.kind = K_GE;  dec_o.opnd2 = imm_sx; end
            C_LT:    begin dec_o.kind = K_LT;  dec_o.opnd2 = imm_sx; end
            C_GEU:   dec_o.kind = K_GEU;
            C_LTU:   dec_o.kind = K_LTU;
            default: dec_o.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/rx_alu_addcmp.sv
module rx_alu_addcmp
    import rx_alu_pkg::*;
(
    input  kind_e           kind_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o
);
    logic [XLEN:0] diff;
    logic          eq, ltu, lts, flag;

    always_comb begin
        diff = {1'b0, a_i} - {1'b0, b_i};
        eq   = (a_i == b_i);
        ltu  = diff[XLEN];
        lts  = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : diff[XLEN-1];
        flag = 1'b0;
        unique case (kind_i)
            K_EQ:    flag = eq;
            K_NE:    flag = !eq;
            K_GE:    flag = !lts;
            K_GEU:   flag = !ltu;
            K_LT:    flag = lts;
            K_LTU:   flag = ltu;
            default: flag = 1'b0;
        endcase
        unique case (kind_i)
            K_ADD:   res_o = a_i + b_i;
            K_SUB:   res_o = diff[XLEN-1:0];
            default: res_o = {{(XLEN-1){1'b0}}, flag};
        endcase
    end
endmodule

// File: rtl/rx_alu_logic.sv
module rx_alu_logic
    import rx_alu_pkg::*;
(
    input  kind_e           kind_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o
);
    always_comb begin
        unique case (kind_i)
            K_AND:   res_o = a_i & b_i;
            K_OR:    res_o = a_i | b_i;
            K_XOR:   res_o = a_i ^ b_i;
            default: res_o = ~(a_i | b_i);
        endcase
    end
endmodule

// File: rtl/rx_alu_shift.sv
module rx_alu_shift
    import rx_alu_pkg::*;
(
    input  kind_e           kind_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [SHW-1:0]  amt_i,
    output logic [XLEN-1:0] res_o
);
    logic            go_right, wrap, fill;
    logic [XLEN-1:0] a_rev, pre, post;
    logic [XLEN-1:0] stage [SHW+1];

    always_comb begin
        go_right = (kind_i == K_SRL) || (kind_i == K_SRA) || (kind_i == K_ROR);
        wrap     = (kind_i == K_ROL) || (kind_i == K_ROR);
        fill     = (kind_i == K_SRA) && a_i[XLEN-1];
    end

    // right-going operations run as left-going ones on the reversed word
    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign a_rev[i] = a_i[XLEN-1-i];
        assign post[i]  = stage[SHW][XLEN-1-i];
    end

    assign pre      = go_right ? a_rev : a_i;
    assign stage[0] = pre;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        logic [STEP-1:0] inj;
        assign inj = wrap ? stage[s][XLEN-1:XLEN-STEP] : {STEP{fill}};
        assign stage[s+1] = amt_i[s] ? {stage[s][XLEN-STEP-1:0], inj} : stage[s];
    end

    assign res_o = go_right ? post : stage[SHW];
endmodule

// File: rtl/rx_int_alu.sv
module rx_int_alu
    import rx_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic [XLEN-1:0]   src_a_i,
    input  logic [XLEN-1:0]   src_b_i,
    output logic [XLEN-1:0]   result_o,
    output logic [RIDX_W-1:0] dest_o,
    output logic              wr_en_o,
    output logic              illegal_o
);
    dec_t            dec;
    logic [XLEN-1:0] r_arith, r_logic, r_shift;
    out_t            out_d, out_q;
    logic            unused_src_idx;

    assign unused_src_idx = ^instr_i[31:27];

    rx_alu_decode u_decode (
        .word_i  (instr_i[26:0]),
        .src_b_i (src_b_i),
        .dec_o   (dec)
    );

    rx_alu_addcmp u_addcmp (
        .kind_i (dec.kind),
        .a_i    (src_a_i),
        .b_i    (dec.opnd2),
        .res_o  (r_arith)
    );

    rx_alu_logic u_logic (
        .kind_i (dec.kind),
        .a_i    (src_a_i),
        .b_i    (dec.opnd2),
        .res_o  (r_logic)
    );

    rx_alu_shift u_shift (
        .kind_i (dec.kind),
        .a_i    (src_a_i),
        .amt_i  (dec.opnd2[SHW-1:0]),
        .res_o  (r_shift)
    );

    always_comb begin
        out_d         = '0;
        out_d.illegal = (dec.kind == K_BAD);
        if (!out_d.illegal) begin
            out_d.dest  = dec.dest;
            out_d.wr_en = (dec.dest != '0);
            unique case (dec.kind)
                K_AND, K_OR, K_XOR, K_NOR:       out_d.result = r_logic;
                K_SLL, K_SRL, K_SRA, K_ROL, K_ROR: out_d.result = r_shift;
                default:                         out_d.result = r_arith;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o  = out_q.result;
    assign dest_o    = out_q.dest;
    assign wr_en_o   = out_q.wr_en;
    assign illegal_o = out_q.illegal;

    // R12: an illegal operation leaves nothing to write
    assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && result_o == '0 && dest_o == '0));

    // R11: register 0 is never written
    assert_no_r0_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (dest_o != '0));

    // R7: a register compare yields 0 or 1
    assert_cmp_bool_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[5:0] == P_REG && (instr_i[16:11] == C_LT || instr_i[16:11] == C_GEU))
        |=> (result_o[XLEN-1:1] == '0 && !illegal_o));

    // R9: rotate by zero returns operand A
    assert_rot_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[5:0] == P_REG && instr_i[16:11] == S_ROL && src_b_i[4:0] == 5'd0)
        |=> (result_o == $past(src_a_i)));

    // R3: immediate form writes to field B
    assert_imm_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[5:0] == P_ADDI) |=> (dest_o == $past(instr_i[26:22]) && !illegal_o));
endmodule

// File: tb/test_rx_int_alu.sv
module test_rx_int_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] a = 32'h0;
    logic [31:0] b = 32'h0;
    logic [31:0] result;
    logic [4:0]  dest;
    logic        wr_en, illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rx_int_alu i_rx_int_alu (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .src_a_i(a), .src_b_i(b),
        .result_o(result), .dest_o(dest), .wr_en_o(wr_en), .illegal_o(illegal)
    );

    // expected outputs for the word currently held at the inputs
    logic [31:0] e_res;
    logic [4:0]  e_dst;
    logic        e_we, e_ill;
    string       e_tag;
    bit          have_exp = 0;

    function automatic logic [31:0] mk_r(logic [4:0] ra, logic [4:0] rb, logic [4:0] rc,
                                         logic [5:0] sec, logic [4:0] sh);
        return {ra, rb, rc, sec, sh, 6'h3A};
    endfunction

    function automatic logic [31:0] mk_i(logic [4:0] ra, logic [4:0] rb,
                                         logic [15:0] imm, logic [5:0] op);
        return {ra, rb, imm, op};
    endfunction

    task automatic model(input logic [31:0] w, input logic [31:0] x, input logic [31:0] y);
        logic [5:0]  op  = w[5:0];
        logic [5:0]  sx  = w[16:11];
        logic [31:0] sxi = {{16{w[21]}}, w[21:6]};
        logic [31:0] zxi = {16'h0, w[21:6]};
        logic [31:0] hii = {w[21:6], 16'h0};
        int          sh;
        logic [63:0] t;
        bit          ok = 1;
        e_res = 0;
        e_dst = (op == 6'h3A) ? w[21:17] : w[26:22];
        if (op == 6'h3A) begin
            sh = (sx == 6'h12 || sx == 6'h1A || sx == 6'h3A || sx == 6'h02) ? int'(w[10:6]) : int'(y[4:0]);
            case (sx)
                6'h31: begin e_res = x + y; e_tag = "R4"; end
                6'h39: begin e_res = x - y; e_tag = "R4"; end
                6'h0E: begin e_res = x & y; e_tag = "R5"; end
                6'h16: begin e_res = x | y; e_tag = "R5"; end
                6'h1E: begin e_res = x ^ y; e_tag = "R5"; end
                6'h06: begin e_res = ~(x | y); e_tag = "R5"; end
                6'h20: begin e_res = 32'(x == y); e_tag = "R7"; end
                6'h18: begin e_res = 32'(x != y); e_tag = "R7"; end
                6'h08: begin e_res = 32'($signed(x) >= $signed(y)); e_tag = "R7"; end
                6'h28: begin e_res = 32'(x >= y); e_tag = "R7"; end
                6'h10: begin e_res = 32'($signed(x) < $signed(y)); e_tag = "R7"; end
                6'h30: begin e_res = 32'(x < y); e_tag = "R7"; end
                6'h13, 6'h12: begin e_res = x << sh; e_tag = (sx == 6'h12) ? "R10" : "R8"; end
                6'h1B, 6'h1A: begin e_res = x >> sh; e_tag = (sx == 6'h1A) ? "R10" : "R8"; end
                6'h3B, 6'h3A: begin e_res = $signed(x) >>> sh; e_tag = (sx == 6'h3A) ? "R10" : "R8"; end
                6'h03, 6'h02: begin t = {x, x} << sh; e_res = t[63:32]; e_tag = (sx == 6'h02) ? "R10" : "R9"; end
                6'h0B: begin t = {x, x} >> sh; e_res = t[31:0]; e_tag = "R9"; end
                default: ok = 0;
            endcase
        end else begin
            case (op)
                6'h04: begin e_res = x + sxi; e_tag = "R4"; end
                6'h0C: begin e_res = x & zxi; e_tag = "R6"; end
                6'h14: begin e_res = x | zxi; e_tag = "R6"; end
                6'h1C: begin e_res = x ^ zxi; e_tag = "R6"; end
                6'h2C: begin e_res = x & hii; e_tag = "R6"; end
                6'h34: begin e_res = x | hii; e_tag = "R6"; end
                6'h3C: begin e_res = x ^ hii; e_tag = "R6"; end
                6'h20: begin e_res = 32'(x == sxi); e_tag = "R7"; end
                6'h18: begin e_res = 32'(x != sxi); e_tag = "R7"; end
                6'h08: begin e_res = 32'($signed(x) >= $signed(sxi)); e_tag = "R7"; end
                6'h10: begin e_res = 32'($signed(x) < $signed(sxi)); e_tag = "R7"; end
                6'h28: begin e_res = 32'(x >= zxi); e_tag = "R7"; end
                6'h30: begin e_res = 32'(x < zxi); e_tag = "R7"; end
                default: ok = 0;
            endcase
        end
        if (!ok) begin
            e_res = 0; e_dst = 0; e_we = 0; e_ill = 1; e_tag = "R12";
        end else begin
            e_ill = 0;
            e_we  = (e_dst != 0);
            if (e_dst == 0) e_tag = {e_tag, "/R11"};
        end
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (result !== e_res || dest !== e_dst || wr_en !== e_we || illegal !== e_ill) begin
            n_bad++;
            $display("FAIL %s(+R2,R3): got res=%h dst=%0d we=%b ill=%b exp res=%h dst=%0d we=%b ill=%b",
                     tag, result, dest, wr_en, illegal, e_res, e_dst, e_we, e_ill);
        end
    endtask

    // one cycle: check the previous word, then present a new one
    task automatic step(input logic [31:0] w, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        if (have_exp) compare(e_tag);
        instr = w; a = x; b = y;
        model(w, x, y);
        have_exp = 1;
    endtask

    initial begin
        logic [5:0] prim_set [13] = '{6'h04, 6'h0C, 6'h14, 6'h1C, 6'h2C, 6'h34, 6'h3C,
                                      6'h20, 6'h18, 6'h08, 6'h10, 6'h28, 6'h30};
        logic [5:0] sec_set [21] = '{6'h31, 6'h39, 6'h0E, 6'h16, 6'h1E, 6'h06, 6'h20,
                                     6'h18, 6'h08, 6'h28, 6'h10, 6'h30, 6'h13, 6'h1B,
                                     6'h3B, 6'h03, 6'h0B, 6'h12, 6'h1A, 6'h3A, 6'h02};
        // R1: outputs held at zero during reset, even with a legal word applied
        instr = mk_r(5'd1, 5'd2, 5'd3, 6'h31, 5'd0); a = 32'h5; b = 32'h7;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (result !== 0 || dest !== 0 || wr_en !== 0 || illegal !== 0) begin
            n_bad++;
            $display("FAIL R1: got res=%h dst=%0d we=%b ill=%b exp all zero", result, dest, wr_en, illegal);
        end
        rst_n = 1'b1;

        // R4 add/sub with wrap, addi sign extension
        step(mk_r(5'd1, 5'd2, 5'd3, 6'h31, 5'd0), 32'h7FFF_FFFF, 32'h1);
        step(mk_r(5'd1, 5'd2, 5'd4, 6'h39, 5'd0), 32'h0, 32'h1);
        step(mk_i(5'd1, 5'd9, 16'hFFFF, 6'h04), 32'h10, 32'hDEAD);
        // R5 register logic
        step(mk_r(5'd1, 5'd2, 5'd5, 6'h06, 5'd0), 32'hF0F0_0000, 32'h0000_0F0F);
        step(mk_r(5'd1, 5'd2, 5'd5, 6'h1E, 5'd0), 32'hFFFF_0000, 32'hFF00_FF00);
        // R6 low zero-extended and high halfword immediates
        step(mk_i(5'd1, 5'd6, 16'hFFFF, 6'h0C), 32'hABCD_1234, 32'h0);
        step(mk_i(5'd1, 5'd6, 16'h8001, 6'h34), 32'h0000_00FF, 32'h0);
        step(mk_i(5'd1, 5'd6, 16'hFFFF, 6'h3C), 32'h1234_5678, 32'h0);
        step(mk_i(5'd1, 5'd6, 16'h00F0, 6'h2C), 32'hFFFF_FFFF, 32'h0);
        // R7 signed vs unsigned compares, immediate extensions
        step(mk_r(5'd1, 5'd2, 5'd7, 6'h10, 5'd0), 32'hFFFF_FFFF, 32'h1);
        step(mk_r(5'd1, 5'd2, 5'd7, 6'h30, 5'd0), 32'hFFFF_FFFF, 32'h1);
        step(mk_r(5'd1, 5'd2, 5'd7, 6'h08, 5'd0), 32'h8000_0000, 32'h8000_0000);
        step(mk_i(5'd1, 5'd7, 16'h8000, 6'h08), 32'hFFFF_8000, 32'h0);
        step(mk_i(5'd1, 5'd7, 16'h8000, 6'h30), 32'h0000_7FFF, 32'h0);
        step(mk_i(5'd1, 5'd7, 16'hFFFF, 6'h20), 32'hFFFF_FFFF, 32'h0);
        step(mk_i(5'd1, 5'd7, 16'hFFFF, 6'h28), 32'hFFFF_FFFF, 32'h0);
        // R8 shifts, upper bits of B ignored, sign fill
        step(mk_r(5'd1, 5'd2, 5'd8, 6'h3B, 5'd0), 32'h8000_0000, 32'hFFFF_FFE4);
        step(mk_r(5'd1, 5'd2, 5'd8, 6'h1B, 5'd0), 32'h8000_0000, 32'h0000_0024);
        step(mk_r(5'd1, 5'd2, 5'd8, 6'h13, 5'd0), 32'h0000_0001, 32'h0000_003F);
        // R9 rotates, with and without wrap
        step(mk_r(5'd1, 5'd2, 5'd9, 6'h03, 5'd0), 32'h8000_0001, 32'h0000_0020);
        step(mk_r(5'd1, 5'd2, 5'd9, 6'h03, 5'd0), 32'h8000_0001, 32'h1);
        step(mk_r(5'd1, 5'd2, 5'd9, 6'h0B, 5'd0), 32'h0000_0003, 32'h1);
        // R10 immediate amounts, B must not matter
        step(mk_r(5'd1, 5'd2, 5'd10, 6'h12, 5'd31), 32'h3, 32'h1);
        step(mk_r(5'd1, 5'd2, 5'd10, 6'h3A, 5'd4), 32'hF000_0000, 32'h0);
        step(mk_r(5'd1, 5'd2, 5'd10, 6'h1A, 5'd4), 32'hF000_0000, 32'h1F);
        step(mk_r(5'd1, 5'd2, 5'd10, 6'h02, 5'd8), 32'h1122_3344, 32'h0);
        // R11 destination zero, both formats
        step(mk_r(5'd1, 5'd2, 5'd0, 6'h31, 5'd0), 32'h2, 32'h3);
        step(mk_i(5'd1, 5'd0, 16'h0005, 6'h04), 32'h2, 32'h0);
        // R12 illegal codes, including aimed at register 0
        step(mk_i(5'd1, 5'd3, 16'h1234, 6'h00), 32'h1, 32'h2);
        step(mk_i(5'd1, 5'd3, 16'h0001, 6'h24), 32'h1, 32'h2);
        step(mk_r(5'd1, 5'd2, 5'd3, 6'h27, 5'd0), 32'h1, 32'h2);
        step(mk_r(5'd1, 5'd2, 5'd0, 6'h25, 5'd0), 32'h1, 32'h2);
        step(mk_i(5'd1, 5'd0, 16'h0000, 6'h3F), 32'h1, 32'h2);

        // mixed pseudo-random traffic, back to back
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] w = $urandom;
            int sel = $urandom_range(0, 9);
            if (sel < 4)       w[5:0] = prim_set[$urandom_range(0, 12)];
            else if (sel < 9) begin
                w[5:0]   = 6'h3A;
                w[16:11] = (sel == 8) ? 6'($urandom) : sec_set[$urandom_range(0, 20)];
            end
            if ($urandom_range(0, 15) == 0) begin
                w[26:22] = 0; w[21:17] = 0;
            end
            step(w, $urandom, ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 40)) : $urandom);
        end
        step(mk_i(5'd0, 5'd0, 16'h0, 6'h00), 32'h0, 32'h0);
        @(negedge clk);
        compare(e_tag);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got run still active, exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule